// File: doc/BRIEF.md
# Dual-Tone Synthesized Channel Source

This block generates the sample words for a multi-channel DAC datapath. Each channel runs two numerically controlled oscillators. Every oscillator has a 16-bit phase accumulator, a static phase offset and a signed amplitude multiplier. The two weighted tones are added and clamped into one signed 16-bit word. A per-channel source code decides what reaches the channel output: the tone sum, words taken from an external valid/ready stream, or a free-running counter ramp.

Software programs the block through a write-only register port. Oscillator settings go into a shadow copy first. A single sync strobe in the global control word then moves every channel's shadow copy into its live copy on the same clock edge, so all channels retune together. A run bit in the same control word holds all oscillators, ramps and outputs at zero while it is low. Registers remain writable while it is low.

Top module: `dds_src`

## Requirements
- R1: Each tone adds its 16-bit increment to its 16-bit accumulator once per clock while running. The tone therefore repeats every 65536/increment samples: an increment of 0x4000 gives a period of 4 and 0x0400 gives a period of 64.
- R2: The table index is the top 6 bits of (accumulator + phase offset), modulo 2^16, so the 16-bit offset spans one full turn. Table entry k for k < 32 is floor(32767·16·u / (5·32² − 4·u)) with u = k·(32 − k). Entry k + 32 is the negative of entry k.
- R3: The scale word is sign-magnitude. Bit 15 is the sign and bits 14:0 are the magnitude, with 14 fraction bits (0x4000 = 1.0). A tone contributes floor(entry·magnitude / 2^14), negated when bit 15 is set.
- R4: With source code 0, the output is the sum of the two tone contributions, clamped to the range −32768..32767.
- R5: Tone writes land in shadow registers and leave the output unchanged until a sync. A sync copies the shadow settings of all channels into the live settings on one clock edge, so the outputs of all channels change in the same cycle.
- R6: The 4-bit source code selects the output: 0 gives the tones, 2 gives the external stream and 11 gives the ramp. Any other code drives the output to 0 from the next cycle.
- R7: While the run bit is 0, every output, accumulator and ramp is held at 0 and no stream word is accepted. Register and sync writes made in this state still take effect once run returns to 1.
- R8: The ramp adds one per clock while running and wraps from 65535 to 0. With code 11 the output shows consecutive ramp values.
- R9: A channel's stream ready output is 1 only while running with code 2. A word presented with valid and ready appears at the output one cycle later. The output holds that word while valid is low.
- R10: Address = {slot, index[2:0]}. Slot 0, index 0 is control: bit 0 is run and bit 1 is a sync strobe that clears itself. Slot c+1 addresses channel c. In a channel slot, index 0 and index 2 are tone 1 and tone 2 {phase[31:16], increment[15:0]}, index 1 and index 3 are their scale in bits [15:0], and index 4 is the source code in bits [3:0]. Writes to any other index or slot have no effect.
- R11: After reset, all outputs are 0, run is 0, stream ready is 0 and every setting and code is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W (5) | Register address {slot, index} |
| wr_data | input | 32 | Register write data |
| ext_data | input | NUM_CH*SAMPLE_W | External stream words, channel c at bits [16c+15:16c] |
| ext_valid | input | NUM_CH | Stream word valid per channel |
| ext_ready | output | NUM_CH | Stream word accepted per channel |
| sample_out | output | NUM_CH*SAMPLE_W | Registered output samples, channel c at bits [16c+15:16c] |

## Verification
The properties assume the register port and the stream inputs change only between clock edges and are never X once reset has been released. The bench keeps to this by driving every input on the falling edge. The ramp-step property applies only while the source code and run bit stay unchanged for two cycles. The bench respects this by writing the code once and then leaving the register port idle for the whole observation window. The stream property compares the output one cycle after acceptance with the word presented at acceptance, so the bench holds each stream word for a full cycle.

// File: rtl/dds_src_pkg.sv
package dds_src_pkg;

  localparam int CFG_W   = 16;
  localparam int TONES   = 2;

  typedef enum logic [3:0] {
    SRC_TONES  = 4'd0,
    SRC_STREAM = 4'd2,
    SRC_RAMP   = 4'd11
  } src_code_e;

  typedef struct packed {
    logic [CFG_W-1:0] phase;
    logic [CFG_W-1:0] incr;
    logic [CFG_W-1:0] scale;
  } tone_cfg_t;

  // Rational sine approximation for a full-wave table of n entries.
  function automatic int sine_point(input int k, input int n, input int amp);
    longint half, kk, u, v;
    half = longint'(n / 2);
    kk   = longint'(k) % half;
    u    = kk * (half - kk);
    v    = (longint'(amp) * 16 * u) / (5 * half * half - 4 * u);
    if (longint'(k) >= half) v = -v;
    return int'(v);
  endfunction

endpackage

// File: rtl/dds_src_tone.sv
module dds_src_tone
  import dds_src_pkg::*;
#(
  parameter int SAMPLE_W = 16,
  parameter int LUT_BITS = 6
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      run,
  input  tone_cfg_t                 cfg,
  output logic signed [SAMPLE_W+1:0] tone_out
);

  localparam int LUT_N  = 1 << LUT_BITS;
  localparam int FRAC_W = CFG_W - 2;
  localparam int PROD_W = SAMPLE_W + CFG_W;
  localparam int AMP    = (1 << (SAMPLE_W - 1)) - 1;

  logic signed [SAMPLE_W-1:0] rom [LUT_N];

  for (genvar g = 0; g < LUT_N; g++) begin : g_rom
    assign rom[g] = SAMPLE_W'(sine_point(g, LUT_N, AMP));
  end

  logic [CFG_W-1:0]            acc;
  logic [CFG_W-1:0]            pt;
  logic signed [SAMPLE_W-1:0]  lut_q;
  logic signed [PROD_W-1:0]    full;
  logic signed [PROD_W-1:0]    shifted;
  logic signed [SAMPLE_W+1:0]  mag_part;
  logic                        unused_bits;

  assign pt       = acc + cfg.phase;
  assign full     = lut_q * $signed({1'b0, cfg.scale[CFG_W-2:0]});
  assign shifted  = full >>> FRAC_W;
  assign mag_part = shifted[SAMPLE_W+1:0];
  assign unused_bits = ^{shifted[PROD_W-1:SAMPLE_W+2], pt[CFG_W-LUT_BITS-1:0]};

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      acc      <= '0;
      lut_q    <= '0;
      tone_out <= '0;
    end else begin
      acc      <= acc + cfg.incr;
      lut_q    <= rom[pt[CFG_W-1 -: LUT_BITS]];
      tone_out <= cfg.scale[CFG_W-1] ? -mag_part : mag_part;
    end
  end

endmodule

// File: rtl/dds_src_chan.sv
module dds_src_chan
  import dds_src_pkg::*;
#(
  parameter int SAMPLE_W = 16,
  parameter int LUT_BITS = 6
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   run,
  input  logic                   sync,
  input  tone_cfg_t [TONES-1:0]  cfg_sh,
  input  logic [3:0]             sel,
  input  logic [SAMPLE_W-1:0]    ext_data,
  input  logic                   ext_valid,
  output logic                   ext_ready,
  output logic [SAMPLE_W-1:0]    sample
);

  localparam int SUM_W = SAMPLE_W + 2 + $clog2(TONES);
  localparam logic signed [SUM_W-1:0] HI = SUM_W'((1 << (SAMPLE_W - 1)) - 1);
  localparam logic signed [SUM_W-1:0] LO = -HI - SUM_W'(1);

  tone_cfg_t [TONES-1:0]       act;
  logic signed [SAMPLE_W+1:0]  tv [TONES];
  logic signed [SUM_W-1:0]     acc_sum;
  logic [SAMPLE_W-1:0]         clamped;
  logic [SAMPLE_W-1:0]         ramp_q;

  always_ff @(posedge clk) begin
    if (rst)       act <= '0;
    else if (sync) act <= cfg_sh;
  end

  for (genvar t = 0; t < TONES; t++) begin : g_tone
    dds_src_tone #(.SAMPLE_W(SAMPLE_W), .LUT_BITS(LUT_BITS)) u_tone (
      .clk      (clk),
      .rst      (rst),
      .run      (run),
      .cfg      (act[t]),
      .tone_out (tv[t])
    );
  end

  always_comb begin
    acc_sum = '0;
    for (int t = 0; t < TONES; t++) acc_sum = acc_sum + SUM_W'(tv[t]);
    if (acc_sum > HI)      clamped = HI[SAMPLE_W-1:0];
    else if (acc_sum < LO) clamped = LO[SAMPLE_W-1:0];
    else                   clamped = acc_sum[SAMPLE_W-1:0];
  end

  assign ext_ready = run && (sel == SRC_STREAM);

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      ramp_q <= '0;
      sample <= '0;
    end else begin
      ramp_q <= ramp_q + SAMPLE_W'(1);
      case (sel)
        SRC_TONES:  sample <= clamped;
        SRC_STREAM: if (ext_valid) sample <= ext_data;
        SRC_RAMP:   sample <= ramp_q;
        default:    sample <= '0;
      endcase
    end
  end

endmodule

// File: rtl/dds_src.sv
module dds_src
  import dds_src_pkg::*;
#(
  parameter int NUM_CH   = 2,
  parameter int SAMPLE_W = 16,
  parameter int LUT_BITS = 6,
  parameter int ADDR_W   = $clog2(NUM_CH + 1) + 3
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       wr_en,
  input  logic [ADDR_W-1:0]          wr_addr,
  input  logic [31:0]                wr_data,
  input  logic [NUM_CH*SAMPLE_W-1:0] ext_data,
  input  logic [NUM_CH-1:0]          ext_valid,
  output logic [NUM_CH-1:0]          ext_ready,
  output logic [NUM_CH*SAMPLE_W-1:0] sample_out
);

  localparam int IDX_W  = 3;
  localparam int SLOT_W = ADDR_W - IDX_W;

  logic [SLOT_W-1:0]         slot;
  logic [IDX_W-1:0]          idx;
  logic                      ctrl_wr;
  logic                      run_q;
  logic                      sync_q;
  logic [NUM_CH-1:0][3:0]    sel_q;
  tone_cfg_t [TONES-1:0]     cfg_sh [NUM_CH];

  assign slot    = wr_addr[ADDR_W-1:IDX_W];
  assign idx     = wr_addr[IDX_W-1:0];
  assign ctrl_wr = wr_en && (slot == '0) && (idx == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q  <= 1'b0;
      sync_q <= 1'b0;
      sel_q  <= '0;
      for (int c = 0; c < NUM_CH; c++) cfg_sh[c] <= '0;
    end else begin
      sync_q <= ctrl_wr && wr_data[1];
      if (ctrl_wr) run_q <= wr_data[0];
      for (int c = 0; c < NUM_CH; c++) begin
        if (wr_en && slot == SLOT_W'(c + 1)) begin
          if (!idx[2]) begin
            if (!idx[0]) begin
              cfg_sh[c][idx[1]].phase <= wr_data[31:16];
              cfg_sh[c][idx[1]].incr  <= wr_data[15:0];
            end else begin
              cfg_sh[c][idx[1]].scale <= wr_data[15:0];
            end
          end else if (idx[1:0] == 2'b00) begin
            sel_q[c] <= wr_data[3:0];
          end
        end
      end
    end
  end

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    dds_src_chan #(.SAMPLE_W(SAMPLE_W), .LUT_BITS(LUT_BITS)) u_chan (
      .clk       (clk),
      .rst       (rst),
      .run       (run_q),
      .sync      (sync_q),
      .cfg_sh    (cfg_sh[c]),
      .sel       (sel_q[c]),
      .ext_data  (ext_data[c*SAMPLE_W +: SAMPLE_W]),
      .ext_valid (ext_valid[c]),
      .ext_ready (ext_ready[c]),
      .sample    (sample_out[c*SAMPLE_W +: SAMPLE_W])
    );
  end

endmodule

// File: rtl/dds_src_chk.sv
module dds_src_chk
  import dds_src_pkg::*;
#(
  parameter int NUM_CH   = 2,
  parameter int SAMPLE_W = 16
) (
  input logic                       clk,
  input logic                       rst,
  input logic                       run,
  input logic [NUM_CH-1:0][3:0]     sel,
  input logic [NUM_CH-1:0]          ext_valid,
  input logic [NUM_CH-1:0]          ext_ready,
  input logic [NUM_CH*SAMPLE_W-1:0] ext_data,
  input logic [NUM_CH*SAMPLE_W-1:0] sample
);

  logic [1:0] cyc;

  always_ff @(posedge clk) begin
    if (rst)             cyc <= '0;
    else if (cyc != 2'd3) cyc <= cyc + 2'd1;
  end

  for (genvar c = 0; c < NUM_CH; c++) begin : g_chk
    // R7: halted core yields zero samples
    a_r7_idle_zero: assert property (@(posedge clk) disable iff (rst)
      (cyc >= 2'd1 && !run) |=> (sample[c*SAMPLE_W +: SAMPLE_W] == '0));

    // R9: an accepted stream word shows up one cycle later
    a_r9_stream_take: assert property (@(posedge clk) disable iff (rst)
      (cyc >= 2'd1 && ext_valid[c] && ext_ready[c])
      |=> (sample[c*SAMPLE_W +: SAMPLE_W] == $past(ext_data[c*SAMPLE_W +: SAMPLE_W])));

    // R8: ramp output steps by one with wrap
    a_r8_ramp_step: assert property (@(posedge clk) disable iff (rst)
      (cyc >= 2'd2 && run && $past(run) && sel[c] == SRC_RAMP && $past(sel[c]) == SRC_RAMP)
      |=> (sample[c*SAMPLE_W +: SAMPLE_W] ==
           $past(sample[c*SAMPLE_W +: SAMPLE_W]) + SAMPLE_W'(1)));

    // R6: unassigned source codes give zero
    a_r6_bad_code_zero: assert property (@(posedge clk) disable iff (rst)
      (cyc >= 2'd1 && run && sel[c] != SRC_TONES && sel[c] != SRC_STREAM && sel[c] != SRC_RAMP)
      |=> (sample[c*SAMPLE_W +: SAMPLE_W] == '0));
  end

endmodule

bind dds_src dds_src_chk #(.NUM_CH(NUM_CH), .SAMPLE_W(SAMPLE_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .run       (run_q),
  .sel       (sel_q),
  .ext_valid (ext_valid),
  .ext_ready (ext_ready),
  .ext_data  (ext_data),
  .sample    (sample_out)
);

// File: tb/dds_src_test.sv
module dds_src_test;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [4:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [31:0] ext_data = '0;
  logic [1:0]  ext_valid = '0;
  logic [1:0]  ext_ready;
  logic [31:0] sample_out;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  dds_src uut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .ext_data(ext_data), .ext_valid(ext_valid), .ext_ready(ext_ready),
    .sample_out(sample_out)
  );

  function automatic int sine_ref(input int k);
    int kk, u, v;
    kk = k % 32;
    u  = kk * (32 - kk);
    v  = (32767 * 16 * u) / (5 * 32 * 32 - 4 * u);
    return (k >= 32) ? -v : v;
  endfunction

  function automatic int tone_ref(input int k, input int sc);
    int p, v;
    p = sine_ref(k) * (sc & 32'h7FFF);
    v = p >>> 14;
    return sc[15] ? -v : v;
  endfunction

  function automatic int sat16(input int v);
    if (v > 32767)  return 32767;
    if (v < -32768) return -32768;
    return v;
  endfunction

  function automatic int sv(input int c);
    return int'($signed(sample_out[c*16 +: 16]));
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input int slot, input int idx, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = {slot[1:0], idx[2:0]}; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic set_tone(input int c, input int t, input int incr, input int ph, input int sc);
    wr(c + 1, t * 2, {ph[15:0], incr[15:0]});
    wr(c + 1, t * 2 + 1, {16'h0, sc[15:0]});
  endtask

  task automatic settle();
    repeat (12) @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R11 ch0 out", sv(0), 0);
    chk("R11 ch1 out", sv(1), 0);
    chk("R11 ready", int'(ext_ready), 0);
  endtask

  task automatic t_static();
    wr(0, 0, 32'h1);
    set_tone(0, 0, 0, 16'h4000, 16'h4000);
    wr(0, 0, 32'h3); settle();
    chk("R2 quarter turn", sv(0), tone_ref(16, 16'h4000));
    set_tone(0, 0, 0, 16'h2000, 16'hC000);
    wr(0, 0, 32'h3); settle();
    chk("R3 negative scale", sv(0), tone_ref(8, 16'hC000));
    set_tone(0, 0, 0, 16'hA000, 16'h2000);
    wr(0, 0, 32'h3); settle();
    chk("R3 half scale", sv(0), tone_ref(40, 16'h2000));
  endtask

  task automatic t_shadow();
    set_tone(0, 0, 0, 16'h6000, 16'h4000);
    settle();
    chk("R5 no sync keeps output", sv(0), tone_ref(40, 16'h2000));
    wr(0, 0, 32'h3); settle();
    chk("R5 sync applies", sv(0), tone_ref(24, 16'h4000));
  endtask

  task automatic t_sync_all();
    int t0, t1;
    t0 = -1; t1 = -1;
    set_tone(0, 0, 0, 16'h1000, 16'h4000);
    set_tone(1, 0, 0, 16'h4000, 16'h4000);
    wr(0, 0, 32'h3);
    for (int i = 0; i < 12; i++) begin
      if (t0 < 0 && sv(0) == tone_ref(4, 16'h4000))  t0 = i;
      if (t1 < 0 && sv(1) == tone_ref(16, 16'h4000)) t1 = i;
      @(negedge clk);
    end
    chk("R5 same change cycle", t0, t1);
    chk("R5 ch1 new value", sv(1), tone_ref(16, 16'h4000));
  endtask

  task automatic t_sum();
    set_tone(1, 0, 0, 16'h2000, 16'h4000);
    set_tone(1, 1, 0, 16'h4000, 16'hA000);
    wr(0, 0, 32'h3); settle();
    chk("R4 mixed sum", sv(1), sat16(tone_ref(8, 16'h4000) + tone_ref(16, 16'hA000)));
    set_tone(1, 0, 0, 16'h4000, 16'h7FFF);
    set_tone(1, 1, 0, 16'h4000, 16'h7FFF);
    wr(0, 0, 32'h3); settle();
    chk("R4 positive clamp", sv(1), 32767);
    set_tone(1, 0, 0, 16'h4000, 16'hFFFF);
    set_tone(1, 1, 0, 16'h4000, 16'hFFFF);
    wr(0, 0, 32'h3); settle();
    chk("R4 negative clamp", sv(1), -32768);
  endtask

  task automatic t_freq();
    int s [128];
    int bad, mx, mn;
    set_tone(0, 0, 16'h4000, 0, 16'h4000);
    wr(0, 0, 32'h3); settle();
    for (int i = 0; i < 8; i++) begin s[i] = sv(0); @(negedge clk); end
    bad = 0; mx = -99999; mn = 99999;
    for (int i = 0; i < 4; i++) begin
      if (s[i] != s[i+4]) bad++;
      if (s[i] > mx) mx = s[i];
      if (s[i] < mn) mn = s[i];
    end
    chk("R1 period 4", bad, 0);
    chk("R1 period 4 peak", mx, 32767);
    chk("R1 period 4 trough", mn, -32767);
    set_tone(0, 0, 16'h0400, 0, 16'h4000);
    wr(0, 0, 32'h3); settle();
    for (int i = 0; i < 128; i++) begin s[i] = sv(0); @(negedge clk); end
    bad = 0; mx = -99999;
    for (int i = 0; i < 64; i++) begin
      if (s[i] != s[i+64]) bad++;
      if (s[i] > mx) mx = s[i];
    end
    chk("R1 period 64", bad, 0);
    chk("R1 period 64 peak", mx, 32767);
  endtask

  task automatic t_stream();
    wr(2, 4, 32'h2);
    chk("R9 ready only stream channel", int'(ext_ready), 2);
    ext_data[31:16] = 16'h1234; ext_valid = 2'b10;
    @(negedge clk);
    ext_valid = 2'b00; ext_data[31:16] = 16'h5555;
    chk("R9 word taken", int'(sample_out[31:16]), 16'h1234);
    repeat (3) @(negedge clk);
    chk("R9 holds without valid", int'(sample_out[31:16]), 16'h1234);
  endtask

  task automatic t_bad_code();
    wr(2, 4, 32'h5);
    repeat (3) @(negedge clk);
    chk("R6 unknown code zero", sv(1), 0);
  endtask

  task automatic t_halt();
    wr(0, 0, 32'h0);
    repeat (2) @(negedge clk);
    chk("R7 halted ch0", sv(0), 0);
    chk("R7 halted ready", int'(ext_ready), 0);
    wr(2, 4, 32'h0);
    set_tone(1, 0, 0, 16'h4000, 16'h4000);
    set_tone(1, 1, 0, 0, 0);
    wr(0, 0, 32'h2); settle();
    chk("R7 halted ch1", sv(1), 0);
    wr(0, 0, 32'h1); settle();
    chk("R7 writes kept", sv(1), 32767);
    wr(2, 5, 32'h0000_000B);
    wr(3, 0, 32'hFFFF_FFFF);
    settle();
    chk("R10 unmapped writes ignored", sv(1), 32767);
  endtask

  task automatic t_ramp();
    int prev, cur, bad, wrapped;
    bad = 0; wrapped = 0;
    wr(1, 4, 32'hB);
    repeat (3) @(negedge clk);
    prev = int'(sample_out[15:0]);
    for (int i = 0; i < 66000; i++) begin
      @(negedge clk);
      cur = int'(sample_out[15:0]);
      if (cur != ((prev + 1) & 32'hFFFF)) bad++;
      if (prev == 65535 && cur == 0) wrapped = 1;
      prev = cur;
    end
    chk("R8 ramp steps", bad, 0);
    chk("R8 ramp wraps", wrapped, 1);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_static();
    t_shadow();
    t_sync_all();
    t_sum();
    t_freq();
    t_stream();
    t_bad_code();
    t_halt();
    t_ramp();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule